// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a load/store processor core. A 5-bit architectural register number is not used as a flat address. Numbers 0 to 7 select one of two global banks of eight registers, and the bank is chosen by an alternate-select input. Numbers 8 to 31 select registers in a circular stack of windows. The current-window pointer picks which window those numbers refer to. Each window owns sixteen registers. Numbers 16 to 31 address the current window's own sixteen. Numbers 8 to 15 alias the first eight registers of the next window up, so a value a caller leaves in its outgoing registers shows up as an incoming register of the callee after a save.

The block has two combinational read ports and one write port that takes effect at the clock edge. Save and restore commands step the window pointer forward or backward, wrapping around the stack of windows. A loadable invalid-window mask blocks moves into windows that are not available. A blocked move raises an overflow or underflow flag for one cycle and leaves the pointer where it was. The window count is a parameter with a legal range of 3 to 32, and the physical storage holds 16 + 16·windows registers of 64 bits.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, the mask has only bit NWIN-1 set, both flags are low, and every register reads as zero.
- R2: Register number 0 reads as zero in both global banks, and a write to number 0 changes nothing.
- R3: Register numbers 1 to 7 of a given global bank return the same storage whatever the window pointer holds.
- R4: With alt_sel high, numbers 0 to 7 use the alternate bank. Writes made in that mode leave the normal bank unchanged, and the reverse also holds.
- R5: Numbers 16 to 31 address the current window's own registers (number 16+k is slot k of window w), so a write in one window is not visible through numbers 16 to 31 of any other window.
- R6: In window w, number 8+k (k from 0 to 7) reads and writes the same storage as number 16+k in window (w+1) mod NWIN.
- R7: A save that is not blocked sets the pointer to (w+1) mod NWIN, a restore that is not blocked sets it to (w+NWIN-1) mod NWIN, and with no command the pointer holds.
- R8: A save whose target window has its mask bit set raises overflow_o for the following cycle and leaves the pointer unchanged. A restore into a masked window does the same with underflow_o.
- R9: When save and restore are requested in the same cycle, only the save acts, and the restore has no effect on the pointer or on underflow_o.
- R10: A read of the register being written in the same cycle returns the old value. The new value is returned from the next cycle on.
- R11: mask_we loads mask_in into the mask at the clock edge. A save or restore in that same cycle is checked against the mask held before the load.
- R12: A write is addressed with the window pointer and alt_sel present in its own cycle, even when a save or restore moves the pointer at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_sel | input | 1 | High selects the alternate global bank for numbers 0 to 7 |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to the next window |
| restore_req | input | 1 | Move to the previous window |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_in | input | NWIN | New invalid-window mask, bit w marks window w |
| cwp_o | output | clog2(NWIN) | Current window pointer |
| mask_o | output | NWIN | Current invalid-window mask |
| overflow_o | output | 1 | One-cycle pulse after a blocked save |
| underflow_o | output | 1 | One-cycle pulse after a blocked restore |

## Verification
Directed sequences first write a global, a local and an outgoing register in one window. They then save and restore and read back through the other windows, which tells a correct window remap apart from a flat address or an off-by-one alias direction. Blocked saves and restores are tried at both ends of the default mask, through the wrap from window 0 to the last window, and in the same cycle as a mask load. These show whether the old or the new mask is consulted. A non-power-of-two window count makes the modulo wrap visible. Seeded random traffic then mixes writes, two-port reads, bank switches and window moves, so that same-cycle write/read and write/save overlaps occur often and are compared against a per-window model in the bench.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  localparam int unsigned GLB_REGS = 8;
  localparam int unsigned WIN_REGS = 16;

  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_OUTER  = 2'd1,
    RGN_LOCAL  = 2'd2
  } rgn_e;

  // Region of an architectural number: 0-7 globals, 8-15 next window, 16-31 own window
  function automatic rgn_e arch_region(input logic [4:0] r);
    if (r[4]) return RGN_LOCAL;
    if (r[3]) return RGN_OUTER;
    return RGN_GLOBAL;
  endfunction

  function automatic int unsigned win_next(input int unsigned w, input int unsigned nwin);
    return (w + 1 >= nwin) ? 0 : w + 1;
  endfunction

  function automatic int unsigned win_prev(input int unsigned w, input int unsigned nwin);
    return (w == 0) ? nwin - 1 : w - 1;
  endfunction

  // Physical slot: [0..7] normal globals, [8..15] alternate globals,
  // then WIN_REGS slots per window, window w starting at 16 + 16*w
  function automatic int unsigned phys_slot(input logic [4:0] r, input int unsigned cwp,
                                            input int unsigned nwin, input logic alt);
    int unsigned slot;
    case (arch_region(r))
      RGN_GLOBAL: slot = (alt ? GLB_REGS : 0) + {29'd0, r[2:0]};
      RGN_OUTER:  slot = 2 * GLB_REGS + win_next(cwp, nwin) * WIN_REGS + {29'd0, r[2:0]};
      default:    slot = 2 * GLB_REGS + cwp * WIN_REGS + {28'd0, r[3:0]};
    endcase
    return slot;
  endfunction

endpackage

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [4:0]    arch_idx,
  input  logic [CW-1:0] cwp,
  input  logic          alt_sel,
  output logic [PW-1:0] phys_idx,
  output logic          is_zero
);

  always_comb begin
    phys_idx = PW'(phys_slot(arch_idx, 32'(cwp), NWIN, alt_sel));
    is_zero  = (arch_idx == 5'd0);
  end

endmodule

// File: rtl/winreg_wptr.sv
module winreg_wptr
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_in,
  output logic [CW-1:0]   cwp,
  output logic [NWIN-1:0] mask,
  output logic            overflow,
  output logic            underflow,
  output logic            save_go,
  output logic            save_blk,
  output logic            rest_go,
  output logic            rest_blk
);

  localparam logic [NWIN-1:0] MASK_RST = {1'b1, {(NWIN-1){1'b0}}};

  logic [CW-1:0]   cwp_q;
  logic [NWIN-1:0] mask_q;
  logic            ovf_q;
  logic            unf_q;
  logic [CW-1:0]   tgt_up;
  logic [CW-1:0]   tgt_dn;
  logic            rest_only;

  always_comb begin
    tgt_up    = CW'(win_next(32'(cwp_q), NWIN));
    tgt_dn    = CW'(win_prev(32'(cwp_q), NWIN));
    rest_only = restore_req && !save_req;
    save_go   = save_req && !mask_q[tgt_up];
    save_blk  = save_req &&  mask_q[tgt_up];
    rest_go   = rest_only && !mask_q[tgt_dn];
    rest_blk  = rest_only &&  mask_q[tgt_dn];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      mask_q <= MASK_RST;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (save_go)      cwp_q <= tgt_up;
      else if (rest_go) cwp_q <= tgt_dn;
      if (mask_we)      mask_q <= mask_in;
      ovf_q <= save_blk;
      unf_q <= rest_blk;
    end
  end

  assign cwp       = cwp_q;
  assign mask      = mask_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NPHYS = 144,
  parameter int unsigned PW    = 8,
  parameter int unsigned NRD   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_phys,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NRD-1:0][PW-1:0]   rd_phys,
  input  logic [NRD-1:0]           rd_zero,
  output logic [NRD-1:0][XLEN-1:0] rd_data
);

  logic [XLEN-1:0] mem_q [NPHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_phys] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_port
      assign rd_data[g] = rd_zero[g] ? '0 : mem_q[rd_phys[g]];
    end
  endgenerate

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter  int unsigned XLEN  = 64,
  parameter  int unsigned NWIN  = 8,
  localparam int unsigned CW    = $clog2(NWIN),
  localparam int unsigned NPHYS = 2 * GLB_REGS + WIN_REGS * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alt_sel,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_in,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] mask_o,
  output logic            overflow_o,
  output logic            underflow_o
);

  localparam int unsigned NRD = 2;

  logic [CW-1:0]             cwp_q;
  logic                      save_go;
  logic                      save_blk;
  logic                      rest_go;
  logic                      rest_blk;
  logic [NRD-1:0][4:0]       rd_idx_v;
  logic [NRD-1:0][PW-1:0]    rd_phys_v;
  logic [NRD-1:0]            rd_zero_v;
  logic [NRD-1:0][XLEN-1:0]  rd_data_v;
  logic [PW-1:0]             wr_phys;
  logic                      wr_zero;
  logic                      wr_commit;

  winreg_wptr #(.NWIN(NWIN), .CW(CW)) u_wptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .restore_req(restore_req),
    .mask_we    (mask_we),
    .mask_in    (mask_in),
    .cwp        (cwp_q),
    .mask       (mask_o),
    .overflow   (overflow_o),
    .underflow  (underflow_o),
    .save_go    (save_go),
    .save_blk   (save_blk),
    .rest_go    (rest_go),
    .rest_blk   (rest_blk)
  );

  assign rd_idx_v = {rd_b_idx, rd_a_idx};

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rdmap
      winreg_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
        .arch_idx(rd_idx_v[g]),
        .cwp     (cwp_q),
        .alt_sel (alt_sel),
        .phys_idx(rd_phys_v[g]),
        .is_zero (rd_zero_v[g])
      );
    end
  endgenerate

  winreg_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_wmap (
    .arch_idx(wr_idx),
    .cwp     (cwp_q),
    .alt_sel (alt_sel),
    .phys_idx(wr_phys),
    .is_zero (wr_zero)
  );

  assign wr_commit = wr_en && !wr_zero;

  winreg_bank #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_commit),
    .wr_phys(wr_phys),
    .wr_data(wr_data),
    .rd_phys(rd_phys_v),
    .rd_zero(rd_zero_v),
    .rd_data(rd_data_v)
  );

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];
  assign cwp_o     = cwp_q;

endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alt_sel,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [4:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            save_req,
  input logic            restore_req,
  input logic            mask_we,
  input logic [NWIN-1:0] mask_in,
  input logic [CW-1:0]   cwp_o,
  input logic [NWIN-1:0] mask_o,
  input logic            overflow_o,
  input logic            underflow_o,
  input logic            save_go,
  input logic            rest_go
);

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp_o) < NWIN); // R7

  AST_R0_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0)); // R2

  AST_R0_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0)); // R2

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> (overflow_o || 32'(cwp_o) == (32'($past(cwp_o)) + 1) % NWIN)); // R7

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req) |=>
      (underflow_o || 32'(cwp_o) == (32'($past(cwp_o)) + NWIN - 1) % NWIN)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req) |=> $stable(cwp_o)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $stable(cwp_o)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> $stable(cwp_o)); // R8

  AST_GO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    save_go |=> !overflow_o); // R8

  AST_GO_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    rest_go |=> !underflow_o); // R8

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o)); // R9

  AST_SAVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> !underflow_o); // R9

  AST_WRITE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && wr_idx == rd_a_idx && !save_req && !restore_req) |=>
      (!$stable(rd_a_idx) || !$stable(alt_sel) || rd_a_data == $past(wr_data))); // R10

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_o == $past(mask_in))); // R11

endmodule

bind winreg_file winreg_chk #(.XLEN(XLEN), .NWIN(NWIN), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alt_sel    (alt_sel),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .rd_b_idx   (rd_b_idx),
  .rd_b_data  (rd_b_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .save_req   (save_req),
  .restore_req(restore_req),
  .mask_we    (mask_we),
  .mask_in    (mask_in),
  .cwp_o      (cwp_o),
  .mask_o     (mask_o),
  .overflow_o (overflow_o),
  .underflow_o(underflow_o),
  .save_go    (save_go),
  .rest_go    (rest_go)
);

// File: tb/sim_winreg_file.sv
`timescale 1ns/1ps
module sim_winreg_file;

  localparam int NW     = 6;
  localparam int CWB    = $clog2(NW);
  localparam int CLK_NS = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            alt_sel = 1'b0;
  logic [4:0]      rd_a_idx = '0;
  logic [63:0]     rd_a_data;
  logic [4:0]      rd_b_idx = '0;
  logic [63:0]     rd_b_data;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_idx = '0;
  logic [63:0]     wr_data = '0;
  logic            save_req = 1'b0;
  logic            restore_req = 1'b0;
  logic            mask_we = 1'b0;
  logic [NW-1:0]   mask_in = '0;
  logic [CWB-1:0]  cwp_o;
  logic [NW-1:0]   mask_o;
  logic            overflow_o;
  logic            underflow_o;

  winreg_file #(.XLEN(64), .NWIN(NW)) u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Bench model: two global banks and per-window slot arrays
  logic [63:0]   mg [2][8];
  logic [63:0]   mw [NW][16];
  int            mcwp;
  logic [NW-1:0] mmask;
  logic          eovf, eunf;

  function automatic logic [63:0] mread(input logic [4:0] r, input logic a);
    int n = int'(r);
    if (n == 0) return 64'd0;
    if (n < 8)  return mg[a][n];
    if (n < 16) return mw[(mcwp + 1) % NW][n - 8];
    return mw[mcwp][n - 16];
  endfunction

  task automatic mwrite(input logic [4:0] r, input logic a, input logic [63:0] v);
    int n = int'(r);
    if (n == 0) return;
    if (n < 8)       mg[a][n] = v;
    else if (n < 16) mw[(mcwp + 1) % NW][n - 8] = v;
    else             mw[mcwp][n - 16] = v;
  endtask

  function automatic string rtag(input string t, input logic [4:0] r);
    if (t != "") return t;
    if (r == 0) return "R2";
    if (r < 8)  return "R3";
    if (r < 16) return "R6";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  // One cycle: drive at the falling edge, check reads, clock, update model, check state
  task automatic cyc(input string tag, input logic we, input logic [4:0] wi, input logic [63:0] wd,
                     input logic [4:0] ra, input logic [4:0] rb, input logic alt,
                     input logic sv, input logic rs, input logic mwe, input logic [NW-1:0] mv);
    int nxt, prv;
    wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
    alt_sel = alt; save_req = sv; restore_req = rs; mask_we = mwe; mask_in = mv;
    #1;
    check(rtag(tag, ra), "read A", rd_a_data, mread(ra, alt));
    check(rtag(tag, rb), "read B", rd_b_data, mread(rb, alt));
    @(posedge clk);
    if (we) mwrite(wi, alt, wd);
    nxt = (mcwp + 1) % NW;
    prv = (mcwp + NW - 1) % NW;
    eovf = 1'b0; eunf = 1'b0;
    if (sv) begin
      if (mmask[nxt]) eovf = 1'b1; else mcwp = nxt;
    end else if (rs) begin
      if (mmask[prv]) eunf = 1'b1; else mcwp = prv;
    end
    if (mwe) mmask = mv;
    @(negedge clk);
    check(tag == "" ? "R7" : tag, "cwp", 64'(cwp_o), 64'(mcwp));
    check(tag == "" ? "R8" : tag, "overflow", 64'(overflow_o), 64'(eovf));
    check(tag == "" ? "R8" : tag, "underflow", 64'(underflow_o), 64'(eunf));
    check(tag == "" ? "R11" : tag, "mask", 64'(mask_o), 64'(mmask));
  endtask

  task automatic idle(input string tag, input logic [4:0] ra, input logic [4:0] rb, input logic alt);
    cyc(tag, 1'b0, 5'd0, 64'd0, ra, rb, alt, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL all: watchdog expired, got %0d checks expected completion", nchk);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 2; b++) for (int i = 0; i < 8; i++) mg[b][i] = '0;
    for (int w = 0; w < NW; w++) for (int i = 0; i < 16; i++) mw[w][i] = '0;
    mcwp = 0;
    mmask = {1'b1, {(NW-1){1'b0}}};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, reads zero across regions
    idle("R1", 5'd17, 5'd5, 1'b0);
    idle("R1", 5'd31, 5'd12, 1'b1);

    // R2: writes to number 0 in both banks are ignored
    cyc("R2", 1'b1, 5'd0, 64'hDEAD_BEEF_0000_0001, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc("R2", 1'b1, 5'd0, 64'hDEAD_BEEF_0000_0002, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    idle("R2", 5'd0, 5'd0, 1'b1);
    idle("R2", 5'd0, 5'd0, 1'b0);

    // R3: global shared across a save
    cyc("R3", 1'b1, 5'd3, 64'h1111_0000_0000_0003, 5'd3, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc("R3", 1'b0, 5'd0, 64'd0, 5'd3, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    idle("R3", 5'd3, 5'd3, 1'b0);

    // R4: alternate bank separate from normal bank
    cyc("R4", 1'b1, 5'd3, 64'h2222_0000_0000_0003, 5'd3, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    idle("R4", 5'd3, 5'd4, 1'b1);
    idle("R4", 5'd3, 5'd4, 1'b0);

    // R5: local privacy (now in window 1)
    cyc("R5", 1'b1, 5'd20, 64'h3333_0000_0000_0020, 5'd20, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc("R5", 1'b0, 5'd0, 64'd0, 5'd20, 5'd20, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    idle("R5", 5'd20, 5'd20, 1'b0);
    cyc("R5", 1'b0, 5'd0, 64'd0, 5'd20, 5'd20, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    idle("R5", 5'd20, 5'd20, 1'b0);

    // R6: outgoing register becomes incoming of next window
    cyc("R6", 1'b1, 5'd10, 64'h4444_0000_0000_0010, 5'd10, 5'd18, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc("R6", 1'b0, 5'd0, 64'd0, 5'd10, 5'd18, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    idle("R6", 5'd18, 5'd10, 1'b0);

    // R8: save up to window 4, then blocked save into window 5
    repeat (2) cyc("R7", 1'b0, 5'd0, 64'd0, 5'd18, 5'd26, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    cyc("R8", 1'b0, 5'd0, 64'd0, 5'd18, 5'd9, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    cyc("R8", 1'b0, 5'd0, 64'd0, 5'd18, 5'd9, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    repeat (4) cyc("R7", 1'b0, 5'd0, 64'd0, 5'd18, 5'd10, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    cyc("R8", 1'b0, 5'd0, 64'd0, 5'd18, 5'd10, 1'b0, 1'b0, 1'b1, 1'b0, '0);

    // R11: mask cleared in the same cycle as a restore; old mask still blocks
    cyc("R11", 1'b0, 5'd0, 64'd0, 5'd1, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    cyc("R7", 1'b0, 5'd0, 64'd0, 5'd16, 5'd8, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    cyc("R7", 1'b0, 5'd0, 64'd0, 5'd16, 5'd8, 1'b0, 1'b1, 1'b0, 1'b0, '0);

    // R9: save and restore together
    cyc("R9", 1'b0, 5'd0, 64'd0, 5'd20, 5'd8, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    idle("R9", 5'd16, 5'd24, 1'b0);

    // R10: write and read same register in one cycle
    cyc("R10", 1'b1, 5'd17, 64'h5555_0000_0000_0017, 5'd17, 5'd17, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    idle("R10", 5'd17, 5'd17, 1'b0);

    // R12: write in the same cycle as a save lands in the old window
    cyc("R12", 1'b1, 5'd16, 64'h6666_0000_0000_0016, 5'd16, 5'd8, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    idle("R12", 5'd16, 5'd8, 1'b0);
    cyc("R12", 1'b1, 5'd2, 64'h7777_0000_0000_0002, 5'd2, 5'd16, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    idle("R12", 5'd16, 5'd2, 1'b1);

    // Restore the default mask
    cyc("R11", 1'b0, 5'd0, 64'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, {1'b1, {(NW-1){1'b0}}});

    // Seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]    wi, ra, rb;
      logic          we, alt, sv, rs, mwe;
      logic [NW-1:0] mv;
      logic [63:0]   wd;
      we  = ($urandom_range(0, 3) != 0);
      wi  = 5'($urandom_range(0, 31));
      wd  = {32'($urandom), 32'($urandom)};
      ra  = ($urandom_range(0, 3) == 0) ? wi : 5'($urandom_range(0, 31));
      rb  = 5'($urandom_range(0, 31));
      alt = ($urandom_range(0, 7) == 0);
      sv  = ($urandom_range(0, 5) == 0);
      rs  = ($urandom_range(0, 5) == 0);
      mwe = ($urandom_range(0, 40) == 0);
      mv  = ($urandom_range(0, 2) == 0) ? '0 : NW'(1) << $urandom_range(0, NW - 1);
      cyc("", we, wi, wd, ra, rb, alt, sv, rs, mwe, mv);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule